// File: doc/BRIEF.md
# Indirect Register File Access Unit

This unit sits on the file-register address path between the core and data RAM. It watches the direct address that each instruction supplies. When that address names the virtual indirect-data slot, the unit replaces it with a pointer-based effective address. The indirect-data slot has no storage of its own, so an access to it always lands somewhere else in RAM.

The effective address has 9 bits. The bank bit from status bit 7 is the top bit, and the 8-bit pointer supplies the rest. The pointer register is an ordinary register at bank offset 0x04, so software can read it, write it and step it through a RAM range. A pointer that resolves back onto the indirect-data slot causes a loop-back access. Such a read returns zero and such a write is dropped.

All resolution is combinational. An indirect access therefore completes in the same cycle as a direct access, and the unit adds no pipeline stage.

Top module: `ind_access_unit`

## Requirements
- R1: A direct address whose low 7 bits (bank offset) are not 0x00 appears unchanged on `ram_addr_o`.
- R2: A direct address whose bank offset is 0x00, in any of the four banks (0x000, 0x080, 0x100, 0x180), drives `ram_addr_o` with the effective address {`bank_i`, `ptr_i`}.
- R3: `bank_i` becomes bit 8 of the effective address, and `ptr_i` becomes bits 7:0.
- R4: An indirect read whose effective address has bank offset 0x00 returns 0x00 on `rdata_o`, whatever RAM returns.
- R5: An indirect write whose effective address has bank offset 0x00 holds `ram_we_o` low.
- R6: On every other access, `ram_we_o` equals `wr_i`, and `ram_wdata_o` always equals `wdata_i`.
- R7: `rdata_o` equals `ram_rdata_i` when `rd_i` is high and the access is not a loop-back access. It is 0x00 whenever `rd_i` is low.
- R8: A direct access to the pointer register at bank offset 0x04 behaves like any plain register: the address passes through and a write is enabled.
- R9: All outputs follow an input change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_addr_i | input | 9 | Direct file address from the instruction, bank already applied |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data from the core |
| ptr_i | input | 8 | Current pointer register value |
| bank_i | input | 1 | Indirect bank bit (status bit 7) |
| ram_rdata_i | input | 8 | Read data returned by RAM |
| ram_addr_o | output | 9 | Resolved RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | Data written to RAM |
| rdata_o | output | 8 | Read data returned to the core |

## Verification
The unit holds no state, so a fault shows at the ports in the same cycle as the access that triggers it. A wrong slot decode shows as an unexpected RAM address. A bank bit placed wrongly shows as an address in the wrong half of RAM. A missing loop-back guard shows as a write enable that should have been blocked, or as nonzero read data. Each directed case and each random access is compared against an independent model right after the inputs settle, so a fault cannot hide behind a later access.

// File: rtl/ind_pkg.sv
package ind_pkg;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned PTR_W   = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OFS_W   = 7;
  localparam int unsigned SLOT_OF = 0;
endpackage

// File: rtl/ind_slot_match.sv
// Flags an address whose bank offset equals the indirect-data slot.
module ind_slot_match #(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned OFS_W   = 7,
  parameter int unsigned SLOT_OF = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [OFS_W-1:0] SLOT = OFS_W'(SLOT_OF);

  always_comb hit_o = (addr_i[OFS_W-1:0] == SLOT);
endmodule

// File: rtl/ind_addr_mux.sv
module ind_addr_mux #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PTR_W  = 8,
  localparam int unsigned BANK_W = ADDR_W - PTR_W
) (
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              use_ind_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    eff_addr_o = {bank_i, ptr_i};
    addr_o     = use_ind_i ? eff_addr_o : dir_addr_i;
  end
endmodule

// File: rtl/ind_access_gate.sv
// Suppresses loop-back accesses: the read returns zero and the write is dropped.
module ind_access_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              block_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              we_o
);
  always_comb begin
    we_o    = wr_i & ~block_i;
    rdata_o = (rd_i && !block_i) ? ram_rdata_i : '0;
  end
endmodule

// File: rtl/ind_access_unit.sv
module ind_access_unit #(
  parameter int unsigned ADDR_W  = ind_pkg::ADDR_W,
  parameter int unsigned PTR_W   = ind_pkg::PTR_W,
  parameter int unsigned DATA_W  = ind_pkg::DATA_W,
  parameter int unsigned OFS_W   = ind_pkg::OFS_W,
  parameter int unsigned SLOT_OF = ind_pkg::SLOT_OF,
  localparam int unsigned BANK_W = ADDR_W - PTR_W
) (
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              dir_hit;
  logic              eff_hit;
  logic              loop_back;
  logic [ADDR_W-1:0] eff_addr;

  ind_slot_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SLOT_OF(SLOT_OF)) u_dir_match (
    .addr_i (dir_addr_i),
    .hit_o  (dir_hit)
  );

  ind_addr_mux #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mux (
    .dir_addr_i (dir_addr_i),
    .bank_i     (bank_i),
    .ptr_i      (ptr_i),
    .use_ind_i  (dir_hit),
    .eff_addr_o (eff_addr),
    .addr_o     (ram_addr_o)
  );

  ind_slot_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SLOT_OF(SLOT_OF)) u_eff_match (
    .addr_i (eff_addr),
    .hit_o  (eff_hit)
  );

  always_comb loop_back = dir_hit & eff_hit;

  ind_access_gate #(.DATA_W(DATA_W)) u_gate (
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .block_i     (loop_back),
    .ram_rdata_i (ram_rdata_i),
    .rdata_o     (rdata_o),
    .we_o        (ram_we_o)
  );

  always_comb ram_wdata_o = wdata_i;
endmodule

// File: rtl/ind_access_unit_chk.sv
module ind_access_unit_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 7
) (
  input logic [ADDR_W-1:0] dir_addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [ADDR_W-PTR_W-1:0] bank_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    // R1
    if (dir_addr_i[OFS_W-1:0] != '0)
      direct_pass_chk: assert (ram_addr_o == dir_addr_i);
    // R3
    if (dir_addr_i[OFS_W-1:0] == '0)
      bank_msb_chk: assert (ram_addr_o[ADDR_W-1] == bank_i[0] && ram_addr_o[PTR_W-1:0] == ptr_i);
    // R5
    if (ram_we_o)
      we_needs_wr_chk: assert (wr_i && !(dir_addr_i[OFS_W-1:0] == '0 && ptr_i[OFS_W-1:0] == '0));
    // R4
    if (dir_addr_i[OFS_W-1:0] == '0 && ptr_i[OFS_W-1:0] == '0)
      loop_read_zero_chk: assert (rdata_o == '0);
    // R7
    if (!rd_i)
      idle_read_zero_chk: assert (rdata_o == '0);
    // R6
    wdata_pass_chk: assert (ram_wdata_o == wdata_i);
  end
endmodule

bind ind_access_unit ind_access_unit_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
) u_chk (
  .dir_addr_i  (dir_addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .ptr_i       (ptr_i),
  .bank_i      (bank_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .ram_wdata_o (ram_wdata_o),
  .rdata_o     (rdata_o)
);

// File: tb/ind_access_unit_tb.sv
module ind_access_unit_tb;
  logic       clk = 1'b0;
  logic [8:0] dir_addr;
  logic       rd, wr, bank;
  logic [7:0] wdata, ptr, ram_rdata;
  logic [8:0] ram_addr;
  logic       ram_we;
  logic [7:0] ram_wdata, rdata;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ind_access_unit u_dut (
    .dir_addr_i(dir_addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .ptr_i(ptr), .bank_i(bank), .ram_rdata_i(ram_rdata),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .rdata_o(rdata)
  );

  function automatic bit m_loop(logic [8:0] d, logic [7:0] p);
    return (d[6:0] == 7'd0) && (p[6:0] == 7'd0);
  endfunction
  function automatic logic [8:0] m_addr(logic [8:0] d, logic b, logic [7:0] p);
    return (d[6:0] == 7'd0) ? {b, p} : d;
  endfunction
  function automatic logic m_we(logic [8:0] d, logic w, logic [7:0] p);
    return w && !m_loop(d, p);
  endfunction
  function automatic logic [7:0] m_rdata(logic [8:0] d, logic r, logic [7:0] p, logic [7:0] rr);
    return (r && !m_loop(d, p)) ? rr : 8'h00;
  endfunction

  task automatic apply(logic [8:0] d, logic r, logic w, logic [7:0] wd,
                       logic [7:0] p, logic b, logic [7:0] rr);
    dir_addr = d; rd = r; wr = w; wdata = wd; ptr = p; bank = b; ram_rdata = rr;
  endtask

  task automatic check(string req);
    logic [8:0] ea = m_addr(dir_addr, bank, ptr);
    logic       ew = m_we(dir_addr, wr, ptr);
    logic [7:0] er = m_rdata(dir_addr, rd, ptr, ram_rdata);
    n_run++;
    if (ram_addr !== ea || ram_we !== ew || rdata !== er || ram_wdata !== wdata) begin
      n_fail++;
      $display("FAIL %s: addr=%h we=%b rdata=%h wdata=%h expected addr=%h we=%b rdata=%h wdata=%h",
               req, ram_addr, ram_we, rdata, ram_wdata, ea, ew, er, wdata);
    end
  endtask

  task automatic step(logic [8:0] d, logic r, logic w, logic [7:0] wd,
                      logic [7:0] p, logic b, logic [7:0] rr, string req);
    @(negedge clk);
    apply(d, r, w, wd, p, b, rr);
    #1 check(req);
  endtask

  initial begin
    void'($urandom(32'h1F3A));
    // idle: no strobes
    step(9'h023, 0, 0, 8'h00, 8'h00, 0, 8'hFF, "R7 idle");
    // R1 direct pass
    step(9'h023, 1, 0, 8'h11, 8'h40, 1, 8'h5A, "R1 direct read");
    step(9'h1FF, 0, 1, 8'h77, 8'h00, 0, 8'h00, "R1 direct write top");
    // R8 pointer register direct
    step(9'h004, 0, 1, 8'h20, 8'h33, 0, 8'h00, "R8 ptr write");
    step(9'h084, 1, 0, 8'h00, 8'h33, 1, 8'h20, "R8 ptr read bank1");
    // R2 indirect from each bank
    step(9'h000, 1, 0, 8'h00, 8'h25, 0, 8'hA5, "R2 bank0 slot");
    step(9'h080, 0, 1, 8'hC3, 8'h2F, 1, 8'h00, "R2 bank1 slot");
    step(9'h100, 1, 0, 8'h00, 8'hFE, 0, 8'h3C, "R2 bank2 slot");
    step(9'h180, 0, 1, 8'h9E, 8'h81, 1, 8'h00, "R2 bank3 slot");
    // R3 bank bit placement
    step(9'h000, 1, 0, 8'h00, 8'h55, 1, 8'h01, "R3 bank high");
    step(9'h000, 1, 0, 8'h00, 8'h55, 0, 8'h01, "R3 bank low");
    // R4/R5 loop-back through pointer 0x00 and 0x80
    step(9'h000, 1, 0, 8'h00, 8'h00, 0, 8'hEE, "R4 loop read");
    step(9'h080, 1, 0, 8'h00, 8'h80, 1, 8'h7F, "R4 loop read ptr80");
    step(9'h000, 0, 1, 8'h44, 8'h00, 1, 8'h00, "R5 loop write");
    step(9'h100, 0, 1, 8'h44, 8'h80, 0, 8'h00, "R5 loop write ptr80");
    // R6 indirect to pointer register still writes
    step(9'h000, 0, 1, 8'h66, 8'h04, 0, 8'h00, "R6 indirect write ptr reg");
    // R9 same-cycle response: change inputs mid-cycle, no edge
    @(posedge clk); #0.5;
    apply(9'h000, 1, 0, 8'h00, 8'h30, 0, 8'h12); #0.5 check("R9 settle a");
    apply(9'h030, 1, 0, 8'h00, 8'h30, 0, 8'h34); #0.5 check("R9 settle b");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [8:0] d = 9'($urandom);
      logic [7:0] p = 8'($urandom);
      if ($urandom_range(3) == 0) d[6:0] = 7'd0;
      if ($urandom_range(7) == 0) p[6:0] = 7'd0;
      step(d, 1'($urandom), 1'($urandom), 8'($urandom), p, 1'($urandom), 8'($urandom),
           "R6 R7 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule